// File: doc/BRIEF.md
# Per-Timeslot External Driver Tristate Control Generator

This block generates the per-timeslot control lines for the external line drivers of the first sixteen serial TDM output streams of a time-division switch. Each stream has its own channel counter. A frame strobe returns the counter to channel 0, and that stream's channel-time tick advances it. The block presents the current channel index of every stream to a connection memory. The memory returns one bit per stream. A 1 means the channel is in use and must be driven; a 0 means the channel is unused and must be high impedance. The block converts that bit into a registered control line: low means drive, high means release.

Each stream has a 2-bit rate code, and that code sets how many control timeslots the stream has per frame. Ticks that arrive after the last channel for the programmed rate are ignored, and the control line stays high until the next frame strobe. Three conditions gate the whole block: a drive-enable pin, an output-standby control bit, and reset. If any of these is inactive, every control line is forced high and a master tristate output for all serial stream outputs is raised.

Top module: `hzc_top`

## Requirements
- R1: While `rst` is sampled high at a clock edge, after that edge every `ext_hz` bit is 1, `ser_hiz` is 1 and every `chan_idx` field is 0.
- R2: After reset is released, every `ext_hz` bit of a stream stays 1 until that stream has seen its first `frame_strobe`, even when both enables are high and ticks arrive.
- R3: A clock edge with `frame_strobe` high sets every stream's `chan_idx` field to 0. This takes priority over a tick in the same cycle. A later edge with `ch_tick[s]` high advances stream s's index by one.
- R4: With both enables high and the stream in range, `ext_hz[s]` after an edge equals the inverse of `drive_bit[s]` sampled at that edge. The sampled bit belongs to the `chan_idx` field shown before the edge (1 = used gives 0 = drive).
- R5: Stream s has 32, 64, 128 or 256 channels for `rate_code[2s+1:2s]` equal to 00, 01, 10 or 11. Once the counter reaches that count, further ticks are ignored and `ext_hz[s]` is 1 until the next frame strobe.
- R6: An edge with `oe_pin` low or `out_enable_bit` low makes every `ext_hz` bit 1 and `ser_hiz` 1 after that edge.
- R7: An edge with `oe_pin`, `out_enable_bit` high and `rst` low makes `ser_hiz` 0 after that edge.
- R8: Each stream counts, limits and converts with its own tick, rate code and drive bit. One stream's inputs have no effect on another stream's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_strobe | input | 1 | Frame start, one cycle wide |
| ch_tick | input | NS | Per-stream channel-boundary tick |
| rate_code | input | NS*2 | Per-stream rate code, 2 bits per stream |
| drive_bit | input | NS | Connection-memory bit for the presented index, 1 = used |
| oe_pin | input | 1 | Drive-enable pin, active high |
| out_enable_bit | input | 1 | Control-register output-standby bit, active high |
| chan_idx | output | NS*8 | Per-stream current channel index |
| ext_hz | output | NS | Per-stream external driver control, 1 = high impedance |
| ser_hiz | output | 1 | Master tristate for all serial outputs, 1 = tristated |

## Verification
The hardest situation to reach is a stream that has run past its rate's channel count while its neighbours are still inside their frames. It matters most for the 256-channel rate, where the counter sits exactly at the width boundary of the index. The stimulus gives each stream its own tick period and a rate code that differs between neighbours. Frames are held open for several hundred cycles, so every rate overflows at a different time. Midway through, the rate codes are swapped, and the enable and reset gates are pulsed while frames are in progress. A behavioural per-stream model is compared on every clock.

// File: rtl/hzc_pkg.sv
package hzc_pkg;
  typedef enum logic [1:0] {
    RATE_X1 = 2'b00,
    RATE_X2 = 2'b01,
    RATE_X4 = 2'b10,
    RATE_X8 = 2'b11
  } rate_e;

  // channels per frame for a rate code: base count doubled per code step
  function automatic int unsigned chan_count(input int unsigned base, input logic [1:0] code);
    return base << code;
  endfunction
endpackage

// File: rtl/hzc_gate.sv
module hzc_gate (
  input  logic clk,
  input  logic rst,
  input  logic oe_pin,
  input  logic out_enable_bit,
  output logic en_now,
  output logic ser_hiz
);
  // three-way gate: both enables high and not in reset
  assign en_now = oe_pin & out_enable_bit & ~rst;

  always_ff @(posedge clk) begin
    if (rst) ser_hiz <= 1'b1;
    else     ser_hiz <= ~(oe_pin & out_enable_bit);
  end
endmodule

// File: rtl/hzc_lane.sv
module hzc_lane #(
  parameter int unsigned BASE_CH = 32,
  parameter int unsigned CNT_W   = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_now,
  input  logic             frame_strobe,
  input  logic             tick,
  input  logic [1:0]       rate,
  input  logic             drive,
  output logic [CNT_W-2:0] idx,
  output logic             hz
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             live;
  logic             in_range;

  assign lim      = CNT_W'(hzc_pkg::chan_count(BASE_CH, rate));
  assign in_range = cnt < lim;
  assign idx      = cnt[CNT_W-2:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      live <= 1'b0;
      hz   <= 1'b1;
    end else begin
      hz <= (en_now && live && in_range) ? ~drive : 1'b1;
      if (frame_strobe) begin
        cnt  <= '0;
        live <= 1'b1;
      end else if (tick && in_range) begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/hzc_top.sv
module hzc_top #(
  parameter int unsigned NS      = 16,
  parameter int unsigned BASE_CH = 32,
  parameter int unsigned RATE_W  = 2,
  localparam int unsigned CNT_W  = $clog2(BASE_CH) + (1 << RATE_W) - 1 + 1,
  localparam int unsigned IDX_W  = CNT_W - 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                frame_strobe,
  input  logic [NS-1:0]       ch_tick,
  input  logic [NS*RATE_W-1:0] rate_code,
  input  logic [NS-1:0]       drive_bit,
  input  logic                oe_pin,
  input  logic                out_enable_bit,
  output logic [NS*IDX_W-1:0] chan_idx,
  output logic [NS-1:0]       ext_hz,
  output logic                ser_hiz
);
  logic en_now;

  hzc_gate u_gate (
    .clk            (clk),
    .rst            (rst),
    .oe_pin         (oe_pin),
    .out_enable_bit (out_enable_bit),
    .en_now         (en_now),
    .ser_hiz        (ser_hiz)
  );

  for (genvar s = 0; s < NS; s++) begin : g_lane
    hzc_lane #(.BASE_CH(BASE_CH), .CNT_W(CNT_W)) u_lane (
      .clk          (clk),
      .rst          (rst),
      .en_now       (en_now),
      .frame_strobe (frame_strobe),
      .tick         (ch_tick[s]),
      .rate         (rate_code[s*RATE_W +: 2]),
      .drive        (drive_bit[s]),
      .idx          (chan_idx[s*IDX_W +: IDX_W]),
      .hz           (ext_hz[s])
    );
  end
endmodule

// File: rtl/hzc_chk.sv
module hzc_chk #(
  parameter int unsigned NS    = 16,
  parameter int unsigned IDX_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                frame_strobe,
  input logic                oe_pin,
  input logic                out_enable_bit,
  input logic [NS*IDX_W-1:0] chan_idx,
  input logic [NS-1:0]       ext_hz,
  input logic                ser_hiz
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!armed)
    rst |=> (&ext_hz && ser_hiz && chan_idx == '0));

  assert_strobe_zero_R3: assert property (@(posedge clk) disable iff (rst || !armed)
    frame_strobe |=> (chan_idx == '0));

  assert_gate_off_R6: assert property (@(posedge clk) disable iff (rst || !armed)
    (!oe_pin || !out_enable_bit) |=> (&ext_hz && ser_hiz));

  assert_master_on_R7: assert property (@(posedge clk) disable iff (rst || !armed)
    (oe_pin && out_enable_bit) |=> !ser_hiz);

  assert_master_implies_lines_R6: assert property (@(posedge clk) disable iff (rst || !armed)
    ser_hiz |-> &ext_hz);
endmodule

bind hzc_top hzc_chk #(.NS(NS), .IDX_W(IDX_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .frame_strobe   (frame_strobe),
  .oe_pin         (oe_pin),
  .out_enable_bit (out_enable_bit),
  .chan_idx       (chan_idx),
  .ext_hz         (ext_hz),
  .ser_hiz        (ser_hiz)
);

// File: tb/test_hzc_top.sv
module test_hzc_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 16;
  localparam int IW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          frame_strobe = 1'b0;
  logic [NS-1:0] ch_tick = '0;
  logic [NS*2-1:0] rate_code = '0;
  logic [NS-1:0] drive_bit;
  logic          oe_pin = 1'b0;
  logic          out_enable_bit = 1'b0;
  logic [NS*IW-1:0] chan_idx;
  logic [NS-1:0] ext_hz;
  logic          ser_hiz;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int tick_mode = 0;
  bit checks_on = 1'b0;
  string cur = "R1";

  bit cm [NS][256];
  int mcnt [NS];
  bit mlive [NS];
  logic [NS-1:0] exp_hz = '1;
  logic exp_ser = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  hzc_top i_hzc_top (
    .clk(clk), .rst(rst), .frame_strobe(frame_strobe), .ch_tick(ch_tick),
    .rate_code(rate_code), .drive_bit(drive_bit), .oe_pin(oe_pin),
    .out_enable_bit(out_enable_bit), .chan_idx(chan_idx), .ext_hz(ext_hz),
    .ser_hiz(ser_hiz)
  );

  // connection memory answering the presented index
  always_comb begin
    for (int s = 0; s < NS; s++) drive_bit[s] = cm[s][chan_idx[s*IW +: IW]];
  end

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    bit en;
    en = oe_pin && out_enable_bit && !rst;
    exp_ser = !en;
    for (int s = 0; s < NS; s++) begin
      int lim;
      lim = 32 << rate_code[s*2 +: 2];
      if (rst || !en || !mlive[s] || mcnt[s] >= lim) exp_hz[s] = 1'b1;
      else exp_hz[s] = !cm[s][mcnt[s]];
      if (rst) begin
        mcnt[s] = 0; mlive[s] = 0;
      end else if (frame_strobe) begin
        mcnt[s] = 0; mlive[s] = 1;
      end else if (ch_tick[s] && mcnt[s] < lim) begin
        mcnt[s] = mcnt[s] + 1;
      end
    end
    checks_on = 1'b1;
  end

  task automatic compare();
    total++;
    if (ser_hiz !== exp_ser) begin
      bad++;
      $display("FAIL %s ser_hiz actual=%b expected=%b cycle=%0d", cur, ser_hiz, exp_ser, cyc);
    end
    for (int s = 0; s < NS; s++) begin
      total++;
      if (ext_hz[s] !== exp_hz[s]) begin
        bad++;
        $display("FAIL %s ext_hz[%0d] actual=%b expected=%b cycle=%0d", cur, s, ext_hz[s], exp_hz[s], cyc);
      end
      total++;
      if (chan_idx[s*IW +: IW] !== IW'(mcnt[s] % 256)) begin
        bad++;
        $display("FAIL %s chan_idx[%0d] actual=%0d expected=%0d cycle=%0d", cur, s,
                 chan_idx[s*IW +: IW], mcnt[s] % 256, cyc);
      end
    end
  endtask

  // sample outputs at the falling edge, then set inputs for the next edge
  task automatic step();
    @(negedge clk);
    cyc++;
    if (checks_on) compare();
    frame_strobe = 1'b0;
    for (int s = 0; s < NS; s++) begin
      if (tick_mode == 0) ch_tick[s] = 1'b0;
      else if (tick_mode == 1) ch_tick[s] = 1'b1;
      else ch_tick[s] = (cyc % (s % 3 + 1)) == 0;
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic strobe();
    step();
    frame_strobe = 1'b1;
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end

  initial begin
    for (int s = 0; s < NS; s++)
      for (int c = 0; c < 256; c++) cm[s][c] = 1'($urandom_range(0, 1));
    for (int s = 0; s < NS; s++) rate_code[s*2 +: 2] = 2'(s % 4);

    cur = "R1"; run(4);
    @(negedge clk); rst = 1'b0; oe_pin = 1'b1; out_enable_bit = 1'b1;
    cur = "R2"; tick_mode = 1; run(20);
    cur = "R3"; strobe(); run(3);
    cur = "R4"; tick_mode = 2; run(150);
    cur = "R5"; run(400);
    cur = "R8";
    for (int s = 0; s < NS; s++) rate_code[s*2 +: 2] = 2'(3 - (s % 4));
    strobe(); run(200);
    cur = "R6"; out_enable_bit = 1'b0; run(30);
    out_enable_bit = 1'b1; oe_pin = 1'b0; run(30);
    cur = "R7"; oe_pin = 1'b1; run(40);
    cur = "R3"; strobe(); tick_mode = 1; run(300);
    cur = "R1"; rst = 1'b1; run(3);
    rst = 1'b0; cur = "R2"; run(20);
    cur = "R5"; strobe(); tick_mode = 2; run(600);
    run(2);
    finish_up();
  end
endmodule